// File: doc/BRIEF.md
# Table-Based Arctangent Frequency-Offset Estimator

This block turns one complex correlation sample into a signed estimate of the fractional carrier frequency offset. The estimate is a fraction of the subcarrier spacing. The correlation arrives as signed 16-bit real and imaginary parts on a valid/ready input.

The block first forms the unsigned ratio |imag| / real in Q3.13 with a bit-serial restoring divider. It then runs an 11-step successive-approximation search over a 2048-entry tangent table. The table is sampled at equal angle steps from 0 to 0.4π, so table index i corresponds directly to an offset magnitude of 0.2·i/2047 spacings. The sign of the imaginary part is applied last, so negative offsets use the same table.

The result leaves on a valid/ready output as a signed Q.15 value, together with a flag for inputs whose real part cannot be mapped. Back-pressure rules:
- An input is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low from acceptance until the result has been consumed, so one estimate is in flight at a time.
- A presented result stays valid and unchanged until `out_ready` is seen high.

Top module: `cfo_atan_est`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: An input is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the result is consumed, and anything driven on the input meanwhile has no effect on the result.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_offset` and `out_range` keep their values. A cycle with both high consumes the result: the next cycle shows `out_valid` 0 and `in_ready` 1.
- R4: For real part re > 0, the ratio is q = floor(|im|·8192 / re) in unsigned Q3.13. If |im| ≥ 8·re, q saturates to 65535.
- R5: Table entry T[i] = floor(tan(0.4π·i/2047)·8192 + 0.5) for i = 0..2047. The selected index is the largest i with T[i] ≤ q.
- R6: The offset magnitude is (i·6554 + 1023) / 2047, using integer division, in Q.15 where 32768 equals one subcarrier spacing.
- R7: `out_offset` is the two's complement negative of the magnitude when im < 0, and the magnitude otherwise.
- R8: When re ≤ 0, `out_range` is 1 and the magnitude is 6554, with the sign taken from im. When re > 0, `out_range` is 0.
- R9: When the angle exceeds 0.4π (q ≥ T[2047]), the magnitude saturates to 6554.
- R10: Whenever `out_valid` is 1, −6554 ≤ `out_offset` ≤ 6554.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Correlation sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_re | input | 16 | Real part, signed |
| in_im | input | 16 | Imaginary part, signed |
| out_valid | output | 1 | Estimate present |
| out_ready | input | 1 | Consumer takes the estimate |
| out_offset | output | 16 | Signed Q.15 offset in subcarrier spacings |
| out_range | output | 1 | Real part was zero or negative |

## Verification
Random real parts are paired with imaginary parts drawn within a few times their size. This sweeps the whole table and both signs, and tests the divider and search against the bench's own tangent table. Directed samples cover the remaining corners:
- a zero imaginary part, which separates index 0 from an off-by-one search;
- ratios far beyond the table, which exercise the divider's saturation and the top-index clamp;
- zero or negative real parts and the most negative imaginary value, which test range flagging and sign handling.

Stall cycles on the output and junk driven on the input while busy show whether held results drift or busy-time inputs leak into the estimate.

// File: rtl/cfo_atan_pkg.sv
package cfo_atan_pkg;

  localparam int IN_W       = 16;
  localparam int RATIO_INT  = 3;
  localparam int RATIO_FRAC = 13;
  localparam int RATIO_W    = RATIO_INT + RATIO_FRAC;
  localparam int IDX_W      = 11;
  localparam int TBL_N      = 1 << IDX_W;
  localparam int OUT_W      = 16;
  // 0.2 of one spacing in Q.15, rounded
  localparam int OFF_MAX    = ((1 << (OUT_W - 1)) * 2 + 5) / 10;

  localparam real PI_VAL     = 3.14159265358979323846;
  localparam real ANGLE_SPAN = 0.4 * PI_VAL;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV,
    ST_SRCH,
    ST_HOLD
  } est_state_e;

  // Tangent of a uniformly spaced angle, scaled to Q3.13 and rounded
  function automatic logic [RATIO_W-1:0] tan_code(input int i, input int n);
    real ang;
    real val;
    ang = ANGLE_SPAN * real'(i) / real'(n - 1);
    val = $tan(ang) * real'(1 << RATIO_FRAC) + 0.5;
    return RATIO_W'($rtoi(val));
  endfunction

endpackage

// File: rtl/cfo_ratio_div.sv
module cfo_ratio_div #(
  parameter int NUM_W  = 16,
  parameter int INT_W  = 3,
  parameter int FRAC_W = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NUM_W-1:0]          num,
  input  logic [NUM_W-1:0]          den,
  output logic                      done,
  output logic [INT_W+FRAC_W-1:0]   quo
);
  localparam int Q_W   = INT_W + FRAC_W;
  localparam int DVD_W = NUM_W + FRAC_W;
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] dvd_r;
  logic [Q_W-1:0]   q_r;
  logic [NUM_W-1:0] rem_r;
  logic [NUM_W-1:0] den_r;
  logic [CNT_W-1:0] cnt_r;
  logic             busy_r;
  logic             done_r;

  logic             sat;
  logic [NUM_W:0]   trial;
  logic             fits;

  // quotient would need more integer bits than provided
  assign sat   = {{INT_W{1'b0}}, num} >= {den, {INT_W{1'b0}}};
  assign trial = {rem_r, dvd_r[DVD_W-1]};
  assign fits  = trial >= {1'b0, den_r};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd_r  <= '0;
      q_r    <= '0;
      rem_r  <= '0;
      den_r  <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start) begin
        if (sat) begin
          q_r    <= '1;
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end else begin
          dvd_r  <= {num, {FRAC_W{1'b0}}};
          rem_r  <= '0;
          q_r    <= '0;
          den_r  <= den;
          cnt_r  <= CNT_W'(DVD_W);
          busy_r <= 1'b1;
        end
      end else if (busy_r) begin
        if (fits) rem_r <= NUM_W'(trial - {1'b0, den_r});
        else      rem_r <= trial[NUM_W-1:0];
        q_r   <= {q_r[Q_W-2:0], fits};
        dvd_r <= dvd_r << 1;
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CNT_W'(1)) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign done = done_r;
  assign quo  = q_r;

endmodule

// File: rtl/cfo_tan_search.sv
module cfo_tan_search
  import cfo_atan_pkg::*;
#(
  parameter int R_W   = RATIO_W,
  parameter int I_W   = IDX_W,
  parameter int N_ENT = TBL_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [R_W-1:0] ratio,
  output logic           done,
  output logic [I_W-1:0] idx
);
  logic [R_W-1:0] rom [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_rom
    assign rom[g] = R_W'(tan_code(g, N_ENT));
  end

  logic [I_W-1:0] idx_r;
  logic [I_W-1:0] probe_r;
  logic [R_W-1:0] ratio_r;
  logic           done_r;
  logic [I_W-1:0] trial;
  logic           take;

  assign trial = idx_r | probe_r;
  assign take  = rom[trial] <= ratio_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_r   <= '0;
      probe_r <= '0;
      ratio_r <= '0;
      done_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start) begin
        idx_r   <= '0;
        probe_r <= {1'b1, {(I_W-1){1'b0}}};
        ratio_r <= ratio;
      end else if (|probe_r) begin
        if (take) idx_r <= trial;
        probe_r <= probe_r >> 1;
        if (probe_r[0]) done_r <= 1'b1;
      end
    end
  end

  assign done = done_r;
  assign idx  = idx_r;

endmodule

// File: rtl/cfo_atan_est.sv
module cfo_atan_est
  import cfo_atan_pkg::*;
#(
  parameter int D_W   = IN_W,
  parameter int O_W   = OUT_W,
  parameter int O_MAX = OFF_MAX
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [D_W-1:0] in_re,
  input  logic [D_W-1:0] in_im,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [O_W-1:0] out_offset,
  output logic           out_range
);
  localparam int HALF_STEP = (TBL_N - 1) / 2;

  est_state_e st_r;
  logic             neg_r;
  logic             range_r;
  logic [O_W-1:0]   off_r;

  logic             accept;
  logic             re_pos;
  logic [D_W-1:0]   im_mag;
  logic             div_start;
  logic             div_done;
  logic [RATIO_W-1:0] ratio;
  logic             srch_start;
  logic             srch_done;
  logic [IDX_W-1:0] srch_idx;
  logic [O_W-1:0]   mag;
  logic [O_W-1:0]   sat_mag;

  assign accept     = (st_r == ST_IDLE) && in_valid;
  assign re_pos     = !in_re[D_W-1] && (|in_re);
  assign im_mag     = in_im[D_W-1] ? (~in_im + 1'b1) : in_im;
  assign div_start  = accept && re_pos;
  assign srch_start = (st_r == ST_DIV) && div_done;
  assign sat_mag    = O_W'(O_MAX);
  assign mag = O_W'((32'(srch_idx) * 32'(O_MAX) + 32'(HALF_STEP)) / 32'(TBL_N - 1));

  cfo_ratio_div #(
    .NUM_W (D_W),
    .INT_W (RATIO_INT),
    .FRAC_W(RATIO_FRAC)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .num  (im_mag),
    .den  (in_re),
    .done (div_done),
    .quo  (ratio)
  );

  cfo_tan_search #(
    .R_W  (RATIO_W),
    .I_W  (IDX_W),
    .N_ENT(TBL_N)
  ) u_srch (
    .clk  (clk),
    .rst_n(rst_n),
    .start(srch_start),
    .ratio(ratio),
    .done (srch_done),
    .idx  (srch_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_r    <= ST_IDLE;
      neg_r   <= 1'b0;
      range_r <= 1'b0;
      off_r   <= '0;
    end else begin
      unique case (st_r)
        ST_IDLE: begin
          if (in_valid) begin
            neg_r <= in_im[D_W-1];
            if (re_pos) begin
              range_r <= 1'b0;
              st_r    <= ST_DIV;
            end else begin
              range_r <= 1'b1;
              off_r   <= in_im[D_W-1] ? (~sat_mag + 1'b1) : sat_mag;
              st_r    <= ST_HOLD;
            end
          end
        end
        ST_DIV: begin
          if (div_done) st_r <= ST_SRCH;
        end
        ST_SRCH: begin
          if (srch_done) begin
            off_r <= neg_r ? (~mag + 1'b1) : mag;
            st_r  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (out_ready) st_r <= ST_IDLE;
        end
        default: st_r <= ST_IDLE;
      endcase
    end
  end

  assign in_ready   = (st_r == ST_IDLE);
  assign out_valid  = (st_r == ST_HOLD);
  assign out_offset = off_r;
  assign out_range  = range_r;

endmodule

// File: rtl/cfo_atan_est_chk.sv
module cfo_atan_est_chk #(
  parameter int O_W   = 16,
  parameter int O_MAX = 6554
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [O_W-1:0] out_offset,
  input logic           out_range
);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offset) && $stable(out_range)));

  a_r3_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  a_r8_range_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_range) |->
      ($signed(out_offset) == O_MAX || $signed(out_offset) == -O_MAX));

  a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_offset) <= O_MAX && $signed(out_offset) >= -O_MAX));

endmodule

bind cfo_atan_est cfo_atan_est_chk #(
  .O_W  (O_W),
  .O_MAX(O_MAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_offset(out_offset),
  .out_range (out_range)
);

// File: tb/cfo_atan_est_test.sv
`timescale 1ns/1ps
module cfo_atan_est_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_re = '0;
  logic [15:0] in_im = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_offset;
  logic        out_range;

  int n_checks = 0;
  int n_fail   = 0;
  int tbl [2048];

  always #4 clk = ~clk;

  cfo_atan_est uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_offset(out_offset), .out_range(out_range)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_off(input int re, input int im, output bit rng);
    int a, q, idx, m;
    a = (im < 0) ? -im : im;
    if (re <= 0) begin
      rng = 1'b1;
      m   = 6554;                                   // R8
    end else begin
      rng = 1'b0;
      q   = (a >= 8 * re) ? 65535 : (a * 8192) / re; // R4
      idx = 0;
      for (int i = 0; i < 2048; i++) if (tbl[i] <= q) idx = i; // R5, R9
      m   = (idx * 6554 + 1023) / 2047;            // R6
    end
    return (im < 0) ? -m : m;                       // R7
  endfunction

  task automatic run_case(input int re, input int im, input int hold, input bit junk,
                          input string tag);
    int  exp_off;
    bit  exp_rng;
    int  waitc;
    exp_off = expect_off(re, im, exp_rng);
    waitc = 0;
    while (!in_ready && waitc < 200) begin @(negedge clk); waitc++; end
    in_re = re[15:0];
    in_im = im[15:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2", int'(in_ready), 0);
    if (junk) begin
      for (int k = 0; k < 3; k++) begin
        in_valid = 1'b1;
        in_re = 16'($urandom);
        in_im = 16'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
    waitc = 0;
    while (!out_valid && waitc < 200) begin @(negedge clk); waitc++; end
    check(out_valid == 1'b1, "R2", int'(out_valid), 1);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(out_valid && $signed(out_offset) == exp_off, "R3",
            $signed(out_offset), exp_off);
    end
    check($signed(out_offset) == exp_off, tag, $signed(out_offset), exp_off);
    check(out_range == exp_rng, "R8", int'(out_range), int'(exp_rng));
    check($signed(out_offset) <= 6554 && $signed(out_offset) >= -6554, "R10",
          $signed(out_offset), 6554);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R3", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int re, im, lim;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++)
      tbl[i] = $rtoi($tan(0.4 * 3.14159265358979323846 * real'(i) / 2047.0) * 8192.0 + 0.5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);

    run_case(1000, 0, 0, 0, "R5");
    run_case(1000, -1, 1, 0, "R7");
    run_case(32767, 32767, 0, 1, "R6");
    run_case(100, 32767, 2, 0, "R9");
    run_case(1, -32768, 0, 0, "R9");
    run_case(4000, 12000, 0, 0, "R4");
    run_case(0, 5, 3, 1, "R8");
    run_case(-100, -5, 0, 0, "R8");
    run_case(0, 0, 0, 0, "R8");
    run_case(-32768, 77, 0, 1, "R8");

    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(9) == 0) re = -int'($urandom_range(32768));
      else re = int'($urandom_range(32767, 1));
      lim = 4 * ((re > 0) ? re : 1000);
      if (lim > 32767) lim = 32767;
      im = int'($urandom_range(2 * lim)) - lim;
      run_case(re, im, int'($urandom_range(3)), 1'($urandom_range(1)), "R6");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule